// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one clock. Software programs it through a small 32-bit register port. One control word holds a run bit and a two-bit step-rate selector for every channel. Each channel also has its own settings word, which holds the period length (`tbase`, counted in steps) and the number of high steps per period (`duty`). A step lasts 1, 8, 64 or 512 clock cycles. The rate comes from a two-stage prescaler: the first stage divides by 8 and the second by 64, and each stage can be switched in on its own.

Each channel is a two-state machine, `CH_IDLE` and `CH_RUN`. Its transitions are:
- **start** (`CH_IDLE`→`CH_RUN`): the run bit is set and the live `tbase` is non-zero.
- **wrap** (`CH_RUN`→`CH_RUN`): the last step of a period ends while `tbase` is non-zero.
- **stop** (`CH_RUN`→`CH_IDLE`): the run bit is cleared, or a period ends while the live `tbase` is zero.

Both **start** and **wrap** copy the live `tbase`, `duty` and selector into shadow registers. A mid-period write therefore never reshapes the pulse that is in progress.

Top module: `pwm_quad`

## Requirements
- R1: There are four channels, numbered 0 to 3. Each output depends only on that channel's own run bit, selector and settings word; every other output stays low while only one channel runs.
- R2: The control word is at byte address 0x00. Bit c is the run bit of channel c, and bits [2c+5:2c+4] are the step-rate selector of channel c. A read returns the stored bits, and bits 31:12 read as zero.
- R3: The settings word of channel c is at byte address 0x04+4c. `tbase` is bits [7:0] and `duty` is bits [23:16]. Every other bit of the word reads as zero, and any unmapped or unaligned address reads as zero.
- R4: Selector value 0 gives a step of 1 clock cycle, 1 gives 8 cycles, 2 gives 64 cycles and 3 gives 512 cycles.
- R5: A period lasts `tbase` steps. The output is high during steps 0 to `duty`-1 and low for the rest of the period. Step 0 begins on the clock edge after the edge that stores the run bit.
- R6: A `duty` of 0 holds the output low. A `duty` of at least `tbase` holds the output high for as long as the channel runs.
- R7: A write to `tbase`, `duty` or the selector of a running channel takes effect only at the next period boundary.
- R8: The output goes low from the edge that clears the run bit. The step counter and the prescaler return to zero, so re-enabling the channel restarts it at step 0.
- R9: A channel whose run bit is set while its `tbase` is 0 keeps its output low.
- R10: Reset clears every register, so all outputs are low and every read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the counters |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Data to write |
| rd_data | output | 32 | Read data, combinational from `addr` |
| pwm_out | output | 4 | One PWM output per channel, bit c for channel c |

## Verification
A wrong internal state becomes visible at `pwm_out` within one period. A step counter that wraps at the wrong count moves the next rising edge. A wrong prescaler stage stretches or shrinks every high phase by a factor of 8. A shadow register that loads too early changes the pulse in the cycle right after the write, not at the boundary. The bench therefore compares every output cycle by cycle, counted from the known start edge, over at least two full periods. Register faults show at once on `rd_data`.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CH_COUNT  = 4;   // number of channels
    localparam int STEP_BITS = 8;   // width of tbase and duty
    localparam int DUTY_LSB  = 16;  // duty field position in a settings word
    localparam int SEL_LSB   = 4;   // first selector field in the control word
    localparam int PRE_LO_W  = 3;   // first prescaler stage: divide by 8
    localparam int PRE_HI_W  = 6;   // second prescaler stage: divide by 64

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
    import pwmq_pkg::*;
#(
    parameter int N_CH   = CH_COUNT,
    parameter int STEP_W = STEP_BITS,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data,
    output logic [N_CH-1:0]                ch_en,
    output logic [N_CH-1:0][1:0]           ch_sel,
    output logic [N_CH-1:0][STEP_W-1:0]    ch_tbase,
    output logic [N_CH-1:0][STEP_W-1:0]    ch_duty
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              ctrl_hit;

    assign word     = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign ctrl_hit = wr_en && aligned && (word == '0);

    // control word: run bits and selectors
    always_ff @(posedge clk) begin
        if (rst) begin
            ch_en  <= '0;
            ch_sel <= '0;
        end else if (ctrl_hit) begin
            ch_en  <= wr_data[N_CH-1:0];
            ch_sel <= wr_data[SEL_LSB +: 2*N_CH];
        end
    end

    // one settings word per channel
    for (genvar c = 0; c < N_CH; c++) begin : g_cfg
        logic cfg_hit;
        assign cfg_hit = wr_en && aligned && (word == WORD_W'(c + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_tbase[c] <= '0;
                ch_duty[c]  <= '0;
            end else if (cfg_hit) begin
                ch_tbase[c] <= wr_data[0 +: STEP_W];
                ch_duty[c]  <= wr_data[DUTY_LSB +: STEP_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (aligned && word == '0) begin
            rd_data[N_CH-1:0]           = ch_en;
            rd_data[SEL_LSB +: 2*N_CH]  = ch_sel;
        end
        for (int c = 0; c < N_CH; c++) begin
            if (aligned && word == WORD_W'(c + 1)) begin
                rd_data[0 +: STEP_W]        = ch_tbase[c];
                rd_data[DUTY_LSB +: STEP_W] = ch_duty[c];
            end
        end
    end

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |=> (ch_en == $past(wr_data[N_CH-1:0])));
endmodule

// File: rtl/pwmq_prescale.sv
module pwmq_prescale #(
    parameter int LO_W = 3,
    parameter int HI_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            lo_carry;

    // selector bit 0 switches in the first stage, bit 1 the second
    always_comb begin
        lo_carry = sel[0] ? (lo_q == '1) : 1'b1;
        tick     = sel[1] ? (lo_carry && hi_q == '1) : lo_carry;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (sel[0])
                lo_q <= lo_q + 1'b1;
            if (sel[1] && lo_carry)
                hi_q <= hi_q + 1'b1;
        end
    end

    // R4
    no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != 2'd0 && !clr) |=> (!tick || sel == 2'd0));
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
    import pwmq_pkg::*;
#(
    parameter int STEP_W = STEP_BITS,
    parameter int LO_W   = PRE_LO_W,
    parameter int HI_W   = PRE_HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        sel,
    input  logic [STEP_W-1:0] tbase,
    input  logic [STEP_W-1:0] duty,
    output logic              pwm
);
    ch_state_e         state_q, state_d;
    logic [STEP_W-1:0] step_q, tb_s, duty_s;
    logic [1:0]        sel_s;
    logic              tick, last_step, wrap, load, pre_clr;

    assign last_step = (step_q == STEP_W'(tb_s - 1'b1));
    assign wrap      = (state_q == CH_RUN) && en && tick && last_step;
    assign pre_clr   = (state_q == CH_IDLE) || wrap || !en;

    pwmq_prescale #(.LO_W(LO_W), .HI_W(HI_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (pre_clr),
        .sel  (sel_s),
        .tick (tick)
    );

    // next state: start, wrap, stop
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (en && tbase != '0) begin
                    state_d = CH_RUN;
                    load    = 1'b1;
                end
            end
            CH_RUN: begin
                if (!en) begin
                    state_d = CH_IDLE;
                end else if (wrap) begin
                    if (tbase == '0) begin
                        state_d = CH_IDLE;
                    end else begin
                        load = 1'b1;
                    end
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_d;
    end

    // step counter and shadow copies
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            tb_s   <= '0;
            duty_s <= '0;
            sel_s  <= '0;
        end else if (load) begin
            step_q <= '0;
            tb_s   <= tbase;
            duty_s <= duty;
            sel_s  <= sel;
        end else if (state_d == CH_IDLE) begin
            step_q <= '0;
        end else if (tick) begin
            step_q <= step_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        pwm = (state_q == CH_RUN) && en && (step_q < duty_s);
    end

    // R5
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_RUN) |-> (step_q < tb_s));

    // R6
    full_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_RUN && en && duty_s >= tb_s) |-> pwm);

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_RUN && !load) |=> ($stable(duty_s) && $stable(tb_s) && $stable(sel_s)));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_IDLE) |-> (step_q == '0 && !pwm));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwmq_pkg::*;
#(
    parameter int N_CH   = CH_COUNT,
    parameter int STEP_W = STEP_BITS,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_CH-1:0]   pwm_out
);
    logic [N_CH-1:0]              ch_en;
    logic [N_CH-1:0][1:0]         ch_sel;
    logic [N_CH-1:0][STEP_W-1:0]  ch_tbase;
    logic [N_CH-1:0][STEP_W-1:0]  ch_duty;

    pwmq_regs #(.N_CH(N_CH), .STEP_W(STEP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ch_en    (ch_en),
        .ch_sel   (ch_sel),
        .ch_tbase (ch_tbase),
        .ch_duty  (ch_duty)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwmq_chan #(.STEP_W(STEP_W), .LO_W(PRE_LO_W), .HI_W(PRE_HI_W)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .en    (ch_en[c]),
            .sel   (ch_sel[c]),
            .tbase (ch_tbase[c]),
            .duty  (ch_duty[c]),
            .pwm   (pwm_out[c])
        );
    end

    // R1
    idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        ((pwm_out & ~ch_en) == '0));
endmodule

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pwm_quad i_pwm_quad (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    // fields: channel[31:24] tbase[23:16] duty[15:8] selector[7:0]
    localparam logic [31:0] VECS [8] = '{
        32'h00_04_02_00,   // half duty, one cycle per step
        32'h01_05_00_00,   // duty 0
        32'h02_03_03_00,   // duty equals tbase
        32'h03_04_07_00,   // duty above tbase
        32'h00_06_01_01,   // step of 8
        32'h01_02_01_02,   // step of 64
        32'h02_02_01_03,   // step of 512
        32'h03_FF_80_00    // largest tbase
    };

    localparam bit SHADOW_EXP [8] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        check(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic run_vec(input int ch, input int tb, input int du, input int sel);
        int div = 1 << (3 * sel);
        int len = 2 * tb * div + 4;
        bit mis = 1'b0;
        logic [3:0] act_s = '0;
        logic [3:0] exp_s = '0;
        wr(8'(4 + 4 * ch), (32'(du) << 16) | 32'(tb));
        wr(8'h00, (32'h1 << ch) | (32'(sel) << (4 + 2 * ch)));
        for (int k = 0; k < len; k++) begin
            logic [3:0] e;
            @(negedge clk);
            e = (((k / div) % tb) < du) ? 4'(1 << ch) : 4'h0;
            if (pwm_out !== e && !mis) begin
                mis   = 1'b1;
                act_s = pwm_out;
                exp_s = e;
            end
        end
        // R1 R4 R5 R6: cycle-exact waveform, other channels low
        check(!mis, "R1 R4 R5 R6 waveform", {28'h0, act_s}, {28'h0, exp_s});
        wr(8'h00, 32'h0);
        // R8: low from the edge that clears the run bit
        check(pwm_out === 4'h0, "R8 stop", {28'h0, pwm_out}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        addr    = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(pwm_out === 4'h0, "R10 outputs", {28'h0, pwm_out}, 32'h0);
        rd_chk(8'h00, 32'h0, "R10 control");
        rd_chk(8'h0C, 32'h0, "R10 settings");

        // R2 control readback; R9 run bits with tbase 0
        wr(8'h00, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check(pwm_out === 4'h0, "R9 zero tbase", {28'h0, pwm_out}, 32'h0);
        rd_chk(8'h00, 32'h0000_0FFF, "R2 control");
        wr(8'h00, 32'h0000_0092);
        rd_chk(8'h00, 32'h0000_0092, "R2 control pattern");
        wr(8'h00, 32'h0);

        // R3 settings readback and unmapped reads
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'h00FF_00FF, "R3 settings");
        rd_chk(8'h14, 32'h0, "R3 unmapped");
        rd_chk(8'h09, 32'h0, "R3 unaligned");
        wr(8'h08, 32'h0);

        foreach (VECS[i]) begin
            run_vec(int'(VECS[i][31:24]), int'(VECS[i][23:16]),
                    int'(VECS[i][15:8]), int'(VECS[i][7:0]));
        end

        // R7: duty rewritten mid-period waits for the boundary
        begin
            bit mis = 1'b0;
            logic [3:0] act_s = '0;
            logic [3:0] exp_s = '0;
            wr(8'h04, 32'h0001_0004);
            wr(8'h00, 32'h1);
            for (int k = 0; k < 8; k++) begin
                if (k == 2) wr(8'h04, 32'h0003_0004);
                else        @(negedge clk);
                if (pwm_out !== {3'b000, SHADOW_EXP[k]} && !mis) begin
                    mis   = 1'b1;
                    act_s = pwm_out;
                    exp_s = {3'b000, SHADOW_EXP[k]};
                end
            end
            check(!mis, "R7 shadowed duty", {28'h0, act_s}, {28'h0, exp_s});
            wr(8'h00, 32'h0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule